// File: doc/BRIEF.md
# Trace byte-count expiry monitor

This block watches the flow of bytes into an on-chip trace buffer and counts them down from a value that software programs. Each cycle in which the byte strobe is high and counting is on takes one off an 11-bit counter. When the counter steps from one to zero, the block raises one of three request lines: a normal interrupt, a non-maskable interrupt or a debug halt. A 2-bit field picks which line, and one setting picks none. The counter then rests at zero. The raised line stays high until software issues a reload request. That request clears the line and copies the programmed start value back into the counter.

Software reaches the block through a simple word-addressed port with separate write and read addresses. The port gives access to a control word, the start value, the live count and a status word. The control word also holds two gate bits, and each one shuts off one of two trace-source paths toward the trace output port. The byte strobe is a plain one-cycle event and has no back-pressure, because every strobe is counted. The request and path-enable outputs are plain levels. The buffer, the interrupt controller and the halt logic sit outside this block.

Top module: `tbc_expiry_monitor`

## Requirements
- R1: After reset every register reads 0, all three request outputs are low and both path enables are high.
- R2: The counter drops by exactly one in each cycle where the byte strobe is high and control bit 0 (enable) is 1. The counter holds its value while the enable bit is 0 or the strobe is low.
- R3: Control bits [2:1] select what an expiry does: 00 does nothing, 01 raises the normal interrupt, 10 raises the non-maskable interrupt and 11 raises the debug halt request. An expiry sets at most one of the three in the cycle the counter becomes 0.
- R4: Writing 1 to control bit 3 makes that bit read back 1 for one cycle, after which it reads 0. In that cycle the counter loads the start value and all pending requests clear, and both changes are visible after the following clock edge.
- R5: Word address 0 is the control word, bits [5:0]. Address 1 holds the start value in bits [10:0], and its upper bits read 0. Address 2 is the live count in bits [10:0], and writes to it are ignored. Address 3 is the status word: bit 1 is the normal interrupt, bit 2 the non-maskable interrupt and bit 3 the halt request. Writes to address 3 are ignored.
- R6: Once the counter is at zero it stays there through further strobes. Those strobes raise no new request.
- R7: A raised request stays high, and stays visible in the status word, through any number of cycles and through control writes that do not set bit 3. Only a reload request clears it.
- R8: Control bit 4 set drives the first path enable low. Control bit 5 set drives the second path enable low.
- R9: When a reload and a counting strobe fall in the same cycle, the reload wins, and the counter holds the full start value afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Word address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| byte_stb | input | 1 | One trace byte written this cycle |
| irq_o | output | 1 | Normal interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request |
| halt_req_o | output | 1 | Debug halt request |
| path0_en_o | output | 1 | First trace-source path enabled |
| path1_en_o | output | 1 | Second trace-source path enabled |

## Verification
A counter that is off by one causes a request to rise one strobe early or late. Since the bench reads the live count after every cycle, the error appears within that same cycle. A response field that is decoded wrongly shows as the wrong line going high on the very edge of expiry. A request flag that does not stay set drops the line in the next quiet cycle. A reload that fires a cycle late, or fails to self-clear, leaves a wrong count or a stale request when the count is read just after the request. A counter that wraps past zero shows up on the first extra strobe.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  typedef enum logic [1:0] {
    RSP_NONE = 2'b00,
    RSP_IRQ  = 2'b01,
    RSP_NMI  = 2'b10,
    RSP_HALT = 2'b11
  } rsp_e;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_RELOAD = 2'd1;
  localparam logic [1:0] A_COUNT  = 2'd2;
  localparam logic [1:0] A_STATUS = 2'd3;

  localparam int CTRL_W   = 6;
  localparam int B_EN     = 0;
  localparam int B_RSP_LO = 1;
  localparam int B_RELOAD = 3;
  localparam int B_PATH0  = 4;
  localparam int B_PATH1  = 5;

  localparam int S_IRQ  = 1;
  localparam int S_NMI  = 2;
  localparam int S_HALT = 3;

  typedef struct packed {
    logic halt;
    logic nmi;
    logic irq;
  } flags_t;
endpackage

// File: rtl/tbc_ctrl_regs.sv
module tbc_ctrl_regs
  import tbc_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cnt_en,
  output rsp_e              rsp,
  output logic              reload_pulse,
  output logic              path0_off,
  output logic              path1_off,
  output logic [CNT_W-1:0]  reload_val,
  output logic [CTRL_W-1:0] ctrl_word
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  rl_q;
  logic              ctrl_wr;
  logic              rl_wr;
  logic              unused_wdata_hi;

  assign ctrl_wr         = wr_en && (wr_addr == A_CTRL);
  assign rl_wr           = wr_en && (wr_addr == A_RELOAD);
  assign unused_wdata_hi = ^wr_data[DATA_W-1:CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rl_q   <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wr_data[CTRL_W-1:0];
      else         ctrl_q[B_RELOAD] <= 1'b0;
      if (rl_wr)   rl_q <= wr_data[CNT_W-1:0];
    end
  end

  assign cnt_en       = ctrl_q[B_EN];
  assign rsp          = rsp_e'(ctrl_q[B_RSP_LO +: 2]);
  assign reload_pulse = ctrl_q[B_RELOAD];
  assign path0_off    = ctrl_q[B_PATH0];
  assign path1_off    = ctrl_q[B_PATH1];
  assign reload_val   = rl_q;
  assign ctrl_word    = ctrl_q;

  // R4: the reload request lasts one cycle unless rewritten
  p_selfclear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_pulse && !(ctrl_wr && wr_data[B_RELOAD])) |=> !reload_pulse);
endmodule

// File: rtl/tbc_down_counter.sv
module tbc_down_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             stb,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step   = en && stb && (cnt_q != '0);
  assign expire = step && !load && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (step)  cnt_q <= cnt_q - ONE;
  end

  assign cnt = cnt_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(en && stb) && !load) |=> $stable(cnt));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stb && !load && cnt != '0) |=> (cnt == $past(cnt) - ONE));
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> (cnt == '0));
  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/tbc_response.sv
module tbc_response
  import tbc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear,
  input  logic   expire,
  input  rsp_e   rsp,
  output flags_t flags
);
  flags_t flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      flags_q <= '0;
    end else if (expire) begin
      case (rsp)
        RSP_IRQ:  flags_q.irq  <= 1'b1;
        RSP_NMI:  flags_q.nmi  <= 1'b1;
        RSP_HALT: flags_q.halt <= 1'b1;
        default:  ;
      endcase
    end
  end

  assign flags = flags_q;

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (flags == '0));
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags != '0) && !clear) |=> (flags == $past(flags)));
endmodule

// File: rtl/tbc_expiry_monitor.sv
module tbc_expiry_monitor
  import tbc_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              byte_stb,
  output logic              irq_o,
  output logic              nmi_o,
  output logic              halt_req_o,
  output logic              path0_en_o,
  output logic              path1_en_o
);
  localparam int PAD_C = DATA_W - CNT_W;
  localparam int PAD_K = DATA_W - CTRL_W;

  logic              cnt_en, reload_pulse, path0_off, path1_off, expire;
  rsp_e              rsp;
  logic [CNT_W-1:0]  reload_val, cnt;
  logic [CTRL_W-1:0] ctrl_word;
  flags_t            flags;
  logic [DATA_W-1:0] status_word;

  tbc_ctrl_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_en(cnt_en), .rsp(rsp),
    .reload_pulse(reload_pulse), .path0_off(path0_off),
    .path1_off(path1_off), .reload_val(reload_val), .ctrl_word(ctrl_word)
  );

  tbc_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .stb(byte_stb),
    .load(reload_pulse), .load_val(reload_val), .cnt(cnt), .expire(expire)
  );

  tbc_response u_rsp (
    .clk(clk), .rst_n(rst_n), .clear(reload_pulse), .expire(expire),
    .rsp(rsp), .flags(flags)
  );

  always_comb begin
    status_word         = '0;
    status_word[S_IRQ]  = flags.irq;
    status_word[S_NMI]  = flags.nmi;
    status_word[S_HALT] = flags.halt;
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:   rd_data = {{PAD_K{1'b0}}, ctrl_word};
      A_RELOAD: rd_data = {{PAD_C{1'b0}}, reload_val};
      A_COUNT:  rd_data = {{PAD_C{1'b0}}, cnt};
      default:  rd_data = status_word;
    endcase
  end

  assign irq_o      = flags.irq;
  assign nmi_o      = flags.nmi;
  assign halt_req_o = flags.halt;
  assign path0_en_o = !path0_off;
  assign path1_en_o = !path1_off;

  // R8: a gate bit set keeps its path enable low
  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[B_PATH0] |-> !path0_en_o) and (ctrl_word[B_PATH1] |-> !path1_en_o));
endmodule

// File: tb/tb_tbc_expiry_monitor.sv
`timescale 1ns/1ps
module tb_tbc_expiry_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        byte_stb = 1'b0;
  logic        irq_o, nmi_o, halt_req_o, path0_en_o, path1_en_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  tbc_expiry_monitor dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .byte_stb(byte_stb), .irq_o(irq_o), .nmi_o(nmi_o),
    .halt_req_o(halt_req_o), .path0_en_o(path0_en_o), .path1_en_o(path1_en_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  function automatic logic [31:0] flags_exp(input int rsp, input bit hit);
    logic [31:0] s = '0;
    if (hit && rsp == 1) s[1] = 1'b1;
    if (hit && rsp == 2) s[2] = 1'b1;
    if (hit && rsp == 3) s[3] = 1'b1;
    return s;
  endfunction

  task automatic chk_lines(input string req, input logic [31:0] st);
    logic [31:0] v;
    rd(2'd3, v);
    chk(req, v, st);
    chk(req, {29'd0, halt_req_o, nmi_o, irq_o}, {29'd0, st[3], st[2], st[1]});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reg", v, 32'd0);
    end
    chk("R1 lines", {27'd0, irq_o, nmi_o, halt_req_o, path0_en_o, path1_en_o}, 32'b11);

    // R5 map: start value width, count and status ignore writes
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R5 reload width", v, 32'h7FF);
    wr(2'd2, 32'h0000_0123);
    rd(2'd2, v); chk("R5 count read-only", v, 32'd0);
    wr(2'd3, 32'hFFFF_FFFF);
    chk_lines("R5 status read-only", 32'd0);

    // R8 gating
    for (int g = 0; g < 4; g++) begin
      wr(2'd0, 32'(g << 4));
      chk("R8 gates", {30'd0, path0_en_o, path1_en_o}, {30'd0, !g[0], !g[1]});
    end

    // R2 hold with enable off; R4 readback of request bit
    wr(2'd1, 32'd5);
    wr(2'd0, 32'h8);
    rd(2'd0, v); chk("R4 request reads 1", v, 32'h8);
    @(negedge clk);
    rd(2'd0, v); chk("R4 request self-clears", v, 32'h0);
    rd(2'd2, v); chk("R4 loaded", v, 32'd5);
    byte_stb = 1'b1;
    repeat (3) @(negedge clk);
    byte_stb = 1'b0;
    rd(2'd2, v); chk("R2 hold while disabled", v, 32'd5);
    wr(2'd0, 32'h1);
    byte_stb = 1'b1;
    repeat (2) @(negedge clk);
    byte_stb = 1'b0;
    @(negedge clk);
    rd(2'd2, v); chk("R2 two strobes", v, 32'd3);

    // Sweep: response x start value x strobe pattern
    for (int rsp = 0; rsp < 4; rsp++) begin
      for (int L = 1; L <= 6; L++) begin
        for (int p = 0; p < 2; p++) begin
          int  expc;
          bit  hit;
          wr(2'd1, 32'(L));
          wr(2'd0, 32'(1 | (rsp << 1) | 8));
          byte_stb = 1'b1;               // collides with the reload cycle
          @(negedge clk);
          byte_stb = 1'b0;
          rd(2'd2, v); chk("R9 reload beats strobe", v, 32'(L));
          chk_lines("R4 requests cleared", 32'd0);
          expc = L; hit = 1'b0;
          for (int s = 0; s < L * 2 + 3; s++) begin
            bit st = (p == 0) || (s % 2 == 0);
            byte_stb = st;
            @(negedge clk);
            byte_stb = 1'b0;
            if (st && expc > 0) begin
              expc--;
              if (expc == 0) hit = 1'b1;
            end
            rd(2'd2, v);
            chk(expc == 0 ? "R6 count at zero" : "R2 count step", v, 32'(expc));
            chk_lines("R3 response", flags_exp(rsp, hit));
          end
          // R7: a control write without the request bit keeps the flag
          wr(2'd0, 32'(1 | (((rsp + 1) % 4) << 1)));
          repeat (2) @(negedge clk);
          chk_lines("R7 sticky", flags_exp(rsp, 1'b1));
        end
      end
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule